// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block sends asynchronous serial frames from a one-byte holding stage that software writes. A separate shift stage produces the frames. A write strobe loads a byte into the holding stage and clears the empty flag. The byte moves into the shift stage on the next baud tick on which the shifter is free, and the empty flag rises in that same cycle. Software can therefore queue the following byte while the current frame is still on the line.

A frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit and a high stop bit. Each bit lasts one baud tick. The parity bit is even or odd, chosen by a parameter. The tick input comes from an external rate generator.

Software may write at any time. If a byte is still waiting in the holding stage, a new write replaces it and the earlier byte is never sent. Software that must not lose data writes only while the empty flag is high. A transmit-end output reports that the line has gone fully quiet.

Top module: `uart_tx_hold`

## Requirements
- R1: One cycle after a cycle with wr_en high, tx_empty is 0 and the holding stage contains that cycle's wr_data.
- R2: tx_empty goes to 1 in the cycle after a baud tick on which the held byte moves into the shift stage, unless a write occurs in that same cycle.
- R3: A write is accepted whatever the value of tx_empty, including while a frame is being sent.
- R4: If a second write arrives before the held byte has moved to the shift stage, only the second byte is transmitted.
- R5: After reset, tx_empty is 1, tx_done is 1 and txd is 1. While nothing is pending, txd stays 1 through any number of baud ticks.
- R6: txd changes only in the cycle after a baud tick. A frame starts with a start bit of 0, followed by the data bits with bit 0 first, and each bit holds for one tick.
- R7: When parity is enabled (the default), a parity bit follows the data bits. The bit is the XOR of the data bits in even mode (the default) and the inverse of that XOR in odd mode.
- R8: The stop bit is 1 and holds for one tick. A transfer into the shift stage happens only on a baud tick, and the start bit appears in the cycle that follows that tick.
- R9: If a byte is pending when the stop bit ends, the tick that ends the stop bit also starts the next frame's start bit, so there is no idle bit between frames.
- R10: tx_done is 1 exactly when the shift stage is idle and tx_empty is 1. It is 0 throughout the stop bit.
- R11: If a write and a transfer happen in the same cycle, the old held byte goes to the shifter and the written byte stays held. In that case tx_empty stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Byte to write |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_empty | output | 1 | Holding stage empty flag |
| tx_done | output | 1 | Shifter idle and holding stage empty |
| txd | output | 1 | Serial output, idles high |

## Verification
The assertions check on every cycle that a write clears the empty flag and captures the byte, and that a transfer raises the flag. They also check that txd moves only after a tick, that each frame starts low and ends with a high stop bit, and that tx_done always coincides with a high line. Other behaviour can only be shown by the bench's scenarios. These include the exact bit sequence and parity value for given bytes in both parity modes, and the loss of an overwritten byte. They also cover the gapless chaining of frames and the result when a write and a transfer land in the same cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2
   } par_mode_e;

   function automatic int frame_bits(input int data_w, input par_mode_e mode);
      return data_w + 2 + ((mode == PAR_NONE) ? 0 : 1);
   endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [DATA_W-1:0] hold_data,
   output logic              empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty     <= 1'b1;
         hold_data <= '0;
      end else if (wr_en) begin
         empty     <= 1'b0;
         hold_data <= wr_data;
      end else if (load) begin
         empty     <= 1'b1;
      end
   end

   p_wr_clears_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!empty && hold_data == $past(wr_data)));

   p_load_sets_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_en) |=> empty);

   p_collide_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load && wr_en) |=> !empty);
endmodule

// File: rtl/tx_parity.sv
module tx_parity
   import uart_tx_pkg::*;
#(
   parameter int        DATA_W = 8,
   parameter par_mode_e MODE   = PAR_EVEN
) (
   input  logic [DATA_W-1:0] data,
   output logic              par
);
   generate
      if (MODE == PAR_EVEN) begin : g_even
         assign par = ^data;
      end else if (MODE == PAR_ODD) begin : g_odd
         assign par = ~(^data);
      end else begin : g_none
         logic unused_bits;
         assign unused_bits = ^data;
         assign par = 1'b0 & unused_bits;
      end
   endgenerate
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int        DATA_W = 8,
   parameter par_mode_e MODE   = PAR_EVEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              pending,
   input  logic [DATA_W-1:0] hold_data,
   output logic              load,
   output logic              busy,
   output logic              txd
);
   localparam int FRAME_W = frame_bits(DATA_W, MODE);
   localparam int CNT_W   = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   cnt;
   logic               busy_q;
   logic               par_bit;
   logic               last_bit;

   tx_parity #(.DATA_W(DATA_W), .MODE(MODE)) par_i (
      .data (hold_data),
      .par  (par_bit)
   );

   generate
      if (MODE == PAR_NONE) begin : g_frame_np
         logic unused_par;
         assign unused_par = par_bit;
         assign frame = {1'b1, hold_data, 1'b0};
      end else begin : g_frame_p
         assign frame = {1'b1, par_bit, hold_data, 1'b0};
      end
   endgenerate

   assign last_bit = busy_q && (cnt == '0);
   assign load     = baud_tick && pending && (!busy_q || last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sreg   <= '1;
         cnt    <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         sreg   <= frame;
         cnt    <= CNT_W'(FRAME_W - 1);
      end else if (baud_tick && busy_q) begin
         if (cnt == '0) begin
            busy_q <= 1'b0;
         end else begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            cnt  <= cnt - CNT_W'(1);
         end
      end
   end

   assign busy = busy_q;
   assign txd  = busy_q ? sreg[0] : 1'b1;

   p_txd_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);

   p_stop_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last_bit |-> txd);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
   import uart_tx_pkg::*;
#(
   parameter int        DATA_W = 8,
   parameter par_mode_e PARITY = PAR_EVEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              baud_tick,
   output logic              tx_empty,
   output logic              tx_done,
   output logic              txd
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_tx_hold: DATA_W must lie between 5 and 9");
      end
   endgenerate

   logic [DATA_W-1:0] hold_data;
   logic              load;
   logic              busy;
   logic              empty;

   tx_hold_reg #(.DATA_W(DATA_W)) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .load      (load),
      .hold_data (hold_data),
      .empty     (empty)
   );

   tx_shifter #(.DATA_W(DATA_W), .MODE(PARITY)) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .pending   (!empty),
      .hold_data (hold_data),
      .load      (load),
      .busy      (busy),
      .txd       (txd)
   );

   assign tx_empty = empty;
   assign tx_done  = !busy && empty;

   p_done_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> txd);
endmodule

// File: tb/uart_tx_hold_tb_top.sv
module uart_tx_hold_tb_top;
   import uart_tx_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       baud_tick = 1'b0;
   logic       tx_empty, tx_done, txd;
   logic       o_empty, o_done, o_txd;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   uart_tx_hold #(.DATA_W(8), .PARITY(PAR_EVEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .baud_tick(baud_tick), .tx_empty(tx_empty), .tx_done(tx_done), .txd(txd)
   );

   uart_tx_hold #(.DATA_W(8), .PARITY(PAR_ODD)) dut_odd_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .baud_tick(baud_tick), .tx_empty(o_empty), .tx_done(o_done), .txd(o_txd)
   );

   // {data byte, expected even parity}
   localparam logic [8:0] VEC [6] = '{
      {8'h00, 1'b0}, {8'hFF, 1'b0}, {8'hA5, 1'b0},
      {8'h01, 1'b1}, {8'h80, 1'b1}, {8'h37, 1'b1}
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic step(input bit wr, input logic [7:0] d, input bit tk);
      @(negedge clk);
      wr_en = wr; wr_data = d; baud_tick = tk;
      @(negedge clk);
      wr_en = 1'b0; baud_tick = 1'b0;
   endtask

   // Checks one frame on both parity variants; the first tick is the load tick unless skip_start.
   task automatic frame_check(input logic [7:0] d, input bit par, input bit skip_start);
      if (!skip_start) begin
         step(1'b0, 8'h00, 1'b1);
         chk(txd == 1'b0, "R6 start bit", txd, 0);
         chk(o_txd == 1'b0, "R6 start bit odd", o_txd, 0);
      end
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 8'h00, 1'b1);
         chk(txd == d[i], "R6 data bit", txd, d[i]);
         chk(o_txd == d[i], "R6 data bit odd", o_txd, d[i]);
      end
      step(1'b0, 8'h00, 1'b1);
      chk(txd == par, "R7 even parity", txd, par);
      chk(o_txd == !par, "R7 odd parity", o_txd, !par);
      step(1'b0, 8'h00, 1'b1);
      chk(txd == 1'b1, "R8 stop bit", txd, 1);
      chk(tx_done == 1'b0, "R10 done low in stop", tx_done, 0);
   endtask

   task automatic end_idle();
      step(1'b0, 8'h00, 1'b1);
      chk(txd == 1'b1, "R5 idle high", txd, 1);
      chk(tx_done == 1'b1, "R10 done after frame", tx_done, 1);
      chk(tx_empty == 1'b1, "R2 empty after frame", tx_empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_empty == 1'b1, "R5 reset empty", tx_empty, 1);
      chk(tx_done == 1'b1, "R5 reset done", tx_done, 1);
      chk(txd == 1'b1, "R5 reset line", txd, 1);
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 8'h00, 1'b1);
         chk(txd == 1'b1, "R5 idle tick", txd, 1);
      end

      // Table-driven frames
      for (int v = 0; v < 6; v++) begin
         step(1'b1, VEC[v][8:1], 1'b0);
         chk(tx_empty == 1'b0, "R1 write clears empty", tx_empty, 0);
         chk(txd == 1'b1, "R8 no load without tick", txd, 1);
         step(1'b0, 8'h00, 1'b1);
         chk(txd == 1'b0, "R8 start after tick", txd, 0);
         chk(tx_empty == 1'b1, "R2 empty on transfer", tx_empty, 1);
         frame_check(VEC[v][8:1], VEC[v][0], 1'b1);
         end_idle();
      end

      // Overwrite before transfer: only second byte goes out
      step(1'b1, 8'h3C, 1'b0);
      step(1'b1, 8'hC3, 1'b0);
      chk(tx_empty == 1'b0, "R3 second write accepted", tx_empty, 0);
      frame_check(8'hC3, 1'b0, 1'b0);
      end_idle();
      chk(txd == 1'b1, "R4 first byte discarded", txd, 1);

      // Back-to-back frames, second write while busy
      step(1'b1, 8'h5A, 1'b0);
      step(1'b0, 8'h00, 1'b1);
      chk(txd == 1'b0, "R6 start of first", txd, 0);
      step(1'b1, 8'h96, 1'b0);
      chk(tx_empty == 1'b0, "R3 write during frame", tx_empty, 0);
      frame_check(8'h5A, 1'b0, 1'b1);
      step(1'b0, 8'h00, 1'b1);
      chk(txd == 1'b0, "R9 gapless start", txd, 0);
      chk(tx_empty == 1'b1, "R2 empty on chained load", tx_empty, 1);
      frame_check(8'h96, 1'b0, 1'b1);
      end_idle();

      // Same-cycle write and transfer
      step(1'b1, 8'h0F, 1'b0);
      step(1'b1, 8'hE1, 1'b1);
      chk(txd == 1'b0, "R11 old byte starts", txd, 0);
      chk(tx_empty == 1'b0, "R11 flag stays clear", tx_empty, 0);
      frame_check(8'h0F, 1'b0, 1'b1);
      frame_check(8'hE1, 1'b0, 1'b0);
      end_idle();

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule